// File: doc/BRIEF.md
# Quad SPI Flash Read Sequencer

This block is the host side of a serial NOR flash read path. It takes one read request at a time and runs it as a single chip-select transaction. The transaction has an opcode phase, an address phase, an optional mode phase, an optional dummy phase and a data phase. The bytes that come back are delivered one per strobe. Three line shapes are supported, written as opcode-address-data widths: 1-1-1, 1-1-4 and 1-4-4. The request also selects a 3-byte or 4-byte address, so stateless 4-byte opcodes can be used without putting the flash into an address mode.

The serial clock runs at half the system clock. The host changes its outputs while the serial clock is low, and samples returning data while the serial clock is high. A request can be flagged as continuous. In that case the opcode phase is left out and the transaction opens with the address. The mode byte sent in the mode phase is what tells the flash whether to stay in continuous mode, so the caller controls entry and exit through that byte.

Top module: `qspi_read_seq`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, rd_valid is 0 and io_oe is 0.
- R2: For a request that is not continuous, the opcode goes out first. It takes 8 serial cycles on io[0], most significant bit first, with io_oe = 4'b0001.
- R3: The address is 24 bits when req_addr4 = 0 (the low 3 bytes of req_addr) and 32 bits when req_addr4 = 1. It goes out most significant bit first. With req_proto 0 or 1 it uses io[0] only (io_oe = 4'b0001), one bit per cycle. With req_proto 2 it uses all four lines (io_oe = 4'b1111), four bits per cycle, with io[3] carrying the most significant bit of each nibble. io_oe only ever takes the values 0, 4'b0001 or 4'b1111.
- R4: The mode phase lasts req_mode_cyc serial cycles and uses the same lines as the address. It sends req_mode_byte most significant first. With four lines, two cycles carry the high nibble and then the low nibble.
- R5: The dummy phase lasts req_wait_cyc cycles. io_oe is 0 from the first dummy cycle until the end of the transaction, and io_oe is 0 whenever cs_n is 1.
- R6: Data phase. req_proto selects the data lines: 0 means 1-1-1 (one bit per cycle on io[1]), 1 means 1-1-4 and 2 means 1-4-4 (four bits per cycle, io[3] most significant). The first bit received is the byte's most significant bit. Each completed byte appears on rd_data with rd_valid high for one clock, while busy is still high, in address order. Exactly req_nbytes bytes are delivered.
- R7: For a 512-byte read with a 3-byte address, the transaction has 1064 serial clock rising edges in 1-1-4 (8 wait cycles, no mode cycles). It has 1044 in 1-4-4 (2 mode cycles, 4 wait cycles).
- R8: When req_cont = 1, no opcode is sent. The first serial cycle after cs_n falls already carries the address.
- R9: cs_n stays low for the whole transaction, and sclk is 0 whenever cs_n is 1. cs_n stays high for at least two clocks between transactions. busy is high from the clock after a request is accepted until cs_n has been high for the gap. A request presented while busy is ignored.
- R10: While cs_n is low, sclk toggles on every clock, so one serial cycle lasts two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when busy is 0 |
| req_opcode | input | 8 | Read opcode |
| req_addr | input | 32 | Start address |
| req_addr4 | input | 1 | 1 selects a 4-byte address, 0 selects 3 bytes |
| req_proto | input | 2 | 0 = 1-1-1, 1 = 1-1-4, 2 = 1-4-4 |
| req_mode_cyc | input | MCYC_W | Number of mode cycles |
| req_wait_cyc | input | WCYC_W | Number of dummy cycles |
| req_mode_byte | input | 8 | Byte sent during the mode cycles |
| req_nbytes | input | LEN_W | Number of bytes to read |
| req_cont | input | 1 | Continuous request: skip the opcode |
| busy | output | 1 | Transaction in progress |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| io_o | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_i | input | 4 | Data line input values |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data valid for one clock |

## Verification
The hardest conditions to reach from the ports are the handoffs between transactions. One is a continuous request that must start straight at the address. Another is a new request issued on the first clock busy falls, where the chip-select gap has to be measured. A third is a request strobed in the middle of a transaction, which must leave no trace. The bench drives these directly. It issues requests back to back as soon as busy drops, and it pulses a conflicting request during a long read. A flash model on the bench counts serial edges and captures every driven line, so each phase boundary can be decoded afterwards against the request that produced it.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_LOAD, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_GAP
  } phase_t;

  localparam logic [1:0] PROTO_111 = 2'd0;
  localparam logic [1:0] PROTO_114 = 2'd1;
  localparam logic [1:0] PROTO_144 = 2'd2;

  localparam int ADDR_W = 32;
  localparam int SH_W   = 32;
endpackage

// File: rtl/qspi_tx_shifter.sv
module qspi_tx_shifter #(
  parameter int SH_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SH_W-1:0] load_val,
  input  logic            load_quad,
  input  logic            shift,
  output logic [3:0]      lanes
);
  logic [SH_W-1:0] sh;
  logic            quad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      quad_q <= 1'b0;
    end else if (load) begin
      sh     <= load_val;
      quad_q <= load_quad;
    end else if (shift) begin
      sh <= quad_q ? {sh[SH_W-5:0], 4'b0000} : {sh[SH_W-2:0], 1'b0};
    end
  end

  assign lanes = quad_q ? sh[SH_W-1:SH_W-4] : {3'b000, sh[SH_W-1]};
endmodule

// File: rtl/qspi_rx_packer.sv
module qspi_rx_packer (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic       quad,
  input  logic [3:0] lanes,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic [7:0] acc;
  logic [2:0] bcnt;
  logic [3:0] nxt_cnt;
  logic [7:0] nxt_acc;

  always_comb begin
    nxt_cnt = {1'b0, bcnt} + (quad ? 4'd4 : 4'd1);
    nxt_acc = quad ? {acc[3:0], lanes} : {acc[6:0], lanes[1]};
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc     <= '0;
      bcnt    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (sample) begin
        acc <= nxt_acc;
        if (nxt_cnt == 4'd8) begin
          bcnt    <= '0;
          byte_o  <= nxt_acc;
          valid_o <= 1'b1;
        end else begin
          bcnt <= nxt_cnt[2:0];
        end
      end
    end
  end
endmodule

// File: rtl/qspi_read_seq.sv
module qspi_read_seq
  import qspi_seq_pkg::*;
#(
  parameter int MCYC_W = 4,
  parameter int WCYC_W = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [31:0]       req_addr,
  input  logic              req_addr4,
  input  logic [1:0]        req_proto,
  input  logic [MCYC_W-1:0] req_mode_cyc,
  input  logic [WCYC_W-1:0] req_wait_cyc,
  input  logic [7:0]        req_mode_byte,
  input  logic [LEN_W-1:0]  req_nbytes,
  input  logic              req_cont,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_i,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int CNT_W = LEN_W + 3;

  phase_t            st;
  logic              half;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_q, cs_n_q;
  logic [3:0]        oe_q;

  logic [7:0]        opcode_q, mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr4_q, quad_addr_q, quad_data_q, cont_q;
  logic [MCYC_W-1:0] mcyc_q;
  logic [WCYC_W-1:0] wcyc_q;
  logic [LEN_W-1:0]  nbytes_q;

  phase_t            after_dummy, after_mode, after_addr, ent_ph;
  logic [CNT_W-1:0]  ent_len;
  logic [SH_W-1:0]   ent_val;
  logic [3:0]        ent_oe;
  logic              ent_quad;
  logic              active, cyc_end, enter;

  // request capture
  always_ff @(posedge clk) begin
    if (st == PH_IDLE && req_valid) begin
      opcode_q    <= req_opcode;
      addr_q      <= req_addr;
      addr4_q     <= req_addr4;
      quad_addr_q <= (req_proto == PROTO_144);
      quad_data_q <= (req_proto == PROTO_114) || (req_proto == PROTO_144);
      mcyc_q      <= req_mode_cyc;
      wcyc_q      <= req_wait_cyc;
      mode_q      <= req_mode_byte;
      nbytes_q    <= req_nbytes;
      cont_q      <= req_cont;
    end
  end

  // phase ordering with empty phases skipped
  always_comb begin
    after_dummy = (nbytes_q != '0) ? PH_DATA : PH_GAP;
    after_mode  = (wcyc_q != '0) ? PH_DUMMY : after_dummy;
    after_addr  = (mcyc_q != '0) ? PH_MODE : after_mode;
    case (st)
      PH_LOAD:  ent_ph = cont_q ? PH_ADDR : PH_CMD;
      PH_CMD:   ent_ph = PH_ADDR;
      PH_ADDR:  ent_ph = after_addr;
      PH_MODE:  ent_ph = after_mode;
      PH_DUMMY: ent_ph = after_dummy;
      default:  ent_ph = PH_GAP;
    endcase
  end

  // per-phase length, shift contents and line enables
  always_comb begin
    ent_len  = '0;
    ent_val  = '0;
    ent_oe   = 4'b0000;
    ent_quad = 1'b0;
    case (ent_ph)
      PH_CMD: begin
        ent_len = CNT_W'(8);
        ent_val = {opcode_q, 24'h000000};
        ent_oe  = 4'b0001;
      end
      PH_ADDR: begin
        if (quad_addr_q) ent_len = addr4_q ? CNT_W'(8) : CNT_W'(6);
        else             ent_len = addr4_q ? CNT_W'(32) : CNT_W'(24);
        ent_val  = addr4_q ? addr_q : {addr_q[23:0], 8'h00};
        ent_oe   = quad_addr_q ? 4'b1111 : 4'b0001;
        ent_quad = quad_addr_q;
      end
      PH_MODE: begin
        ent_len  = CNT_W'(mcyc_q);
        ent_val  = {mode_q, 24'h000000};
        ent_oe   = quad_addr_q ? 4'b1111 : 4'b0001;
        ent_quad = quad_addr_q;
      end
      PH_DUMMY: ent_len = CNT_W'(wcyc_q);
      PH_DATA:  ent_len = quad_data_q ? (CNT_W'(nbytes_q) << 1) : (CNT_W'(nbytes_q) << 3);
      PH_GAP:   ent_len = CNT_W'(2);
      default:  ent_len = '0;
    endcase
  end

  assign active  = (st == PH_CMD) || (st == PH_ADDR) || (st == PH_MODE) ||
                   (st == PH_DUMMY) || (st == PH_DATA);
  assign cyc_end = active && half;
  assign enter   = (st == PH_LOAD) || (cyc_end && cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PH_IDLE;
      half   <= 1'b0;
      cnt    <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      oe_q   <= 4'b0000;
    end else begin
      case (st)
        PH_IDLE: if (req_valid) st <= PH_LOAD;
        PH_LOAD: begin
          st     <= ent_ph;
          cnt    <= ent_len;
          oe_q   <= ent_oe;
          cs_n_q <= 1'b0;
          half   <= 1'b0;
        end
        PH_GAP: begin
          if (cnt == CNT_W'(1)) st <= PH_IDLE;
          else                  cnt <= cnt - 1'b1;
        end
        default: begin
          if (!half) begin
            sclk_q <= 1'b1;
            half   <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            half   <= 1'b0;
            if (cnt == CNT_W'(1)) begin
              st   <= ent_ph;
              cnt  <= ent_len;
              oe_q <= ent_oe;
              if (ent_ph == PH_GAP) cs_n_q <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
      endcase
    end
  end

  qspi_tx_shifter #(.SH_W(SH_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .load      (enter),
    .load_val  (ent_val),
    .load_quad (ent_quad),
    .shift     (cyc_end && cnt != CNT_W'(1)),
    .lanes     (io_o)
  );

  qspi_rx_packer rx_i (
    .clk     (clk),
    .rst     (rst),
    .clear   (st == PH_LOAD),
    .sample  (cyc_end && st == PH_DATA),
    .quad    (quad_data_q),
    .lanes   (io_i),
    .byte_o  (rd_data),
    .valid_o (rd_valid)
  );

  assign busy  = (st != PH_IDLE);
  assign cs_n  = cs_n_q;
  assign sclk  = sclk_q;
  assign io_oe = oe_q;
endmodule

// File: rtl/qspi_read_seq_chk.sv
module qspi_read_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic       rd_valid
);
  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  assert_idle_deselect_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);
  assert_gap_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n);
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (io_oe == 4'b0000));
  assert_lane_set_R3: assert property (@(posedge clk) disable iff (rst)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));
  assert_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$past(cs_n)) |-> (sclk != $past(sclk)));
  assert_byte_in_txn_R6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
endmodule

bind qspi_read_seq qspi_read_seq_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .cs_n     (cs_n),
  .sclk     (sclk),
  .io_oe    (io_oe),
  .rd_valid (rd_valid)
);

// File: tb/qspi_read_seq_tb_top.sv
module qspi_read_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [31:0] req_addr = '0;
  logic        req_addr4 = 1'b0;
  logic [1:0]  req_proto = '0;
  logic [3:0]  req_mode_cyc = '0;
  logic [4:0]  req_wait_cyc = '0;
  logic [7:0]  req_mode_byte = '0;
  logic [15:0] req_nbytes = '0;
  logic        req_cont = 1'b0;
  logic        busy, cs_n, sclk, rd_valid;
  logic [3:0]  io_o, io_oe;
  logic [3:0]  io_i = '0;
  logic [7:0]  rd_data;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];

  // flash model state
  logic [3:0] cap_o [0:4095];
  logic [3:0] cap_oe[0:4095];
  int nrise = 0;
  int cur_d = 1000000;
  bit cur_quad = 0;
  logic [31:0] cur_addr = '0;
  int n_sel = 0;
  int hi_run = 0;
  int min_gap = 1000;

  always #10 clk = ~clk;

  qspi_read_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_addr4(req_addr4), .req_proto(req_proto),
    .req_mode_cyc(req_mode_cyc), .req_wait_cyc(req_wait_cyc),
    .req_mode_byte(req_mode_byte), .req_nbytes(req_nbytes), .req_cont(req_cont),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .io_o(io_o), .io_oe(io_oe),
    .io_i(io_i), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [7:0] fbyte(logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge cs_n) begin
    nrise = 0;
    n_sel++;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (nrise < 4096) begin
      cap_o[nrise]  = io_o;
      cap_oe[nrise] = io_oe;
    end
    nrise++;
  end

  always @(negedge sclk) if (!cs_n && nrise >= cur_d) begin
    int j;
    logic [7:0] b;
    j = nrise - cur_d;
    if (cur_quad) begin
      b = fbyte(cur_addr + 32'(j / 2));
      io_i = (j % 2 == 0) ? b[7:4] : b[3:0];
    end else begin
      b = fbyte(cur_addr + 32'(j / 8));
      io_i = {2'b00, b[7 - (j % 8)], 1'b0};
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (cs_n) hi_run++;
      else begin
        if (hi_run > 0 && n_sel > 1 && hi_run < min_gap) min_gap = hi_run;
        hi_run = 0;
      end
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 data byte", rd_data, e);
        end
      end
    end
  end

  task automatic run(input logic [7:0] opc, input logic [31:0] addr, input bit a4,
                     input logic [1:0] proto, input int mcyc, input int wcyc,
                     input logic [7:0] mb, input int n, input bit cont,
                     input bit poke_busy);
    int al, ac, off, dl, total;
    logic [31:0] ga;
    logic [7:0] gb;
    bit oe_ok;
    al  = (proto == 2'd2) ? 4 : 1;
    ac  = (a4 ? 32 : 24) / al;
    off = cont ? 0 : 8;
    dl  = (proto == 2'd0) ? 1 : 4;
    total = off + ac + mcyc + wcyc + n * 8 / dl;
    cur_d = off + ac + mcyc + wcyc;
    cur_quad = (dl == 4);
    cur_addr = a4 ? addr : {8'h00, addr[23:0]};
    for (int i = 0; i < n; i++) exp_q.push_back(fbyte(cur_addr + 32'(i)));
    @(negedge clk);
    while (busy) @(negedge clk);
    req_opcode = opc; req_addr = addr; req_addr4 = a4; req_proto = proto;
    req_mode_cyc = 4'(mcyc); req_wait_cyc = 5'(wcyc); req_mode_byte = mb;
    req_nbytes = 16'(n); req_cont = cont; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      req_opcode = 8'h03; req_addr = 32'h00FFFF00; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(nrise == total, "R7 R10 serial cycle total", nrise, total);
    chk(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);
    if (!cont) begin
      gb = '0; oe_ok = 1;
      for (int i = 0; i < 8; i++) begin
        gb = {gb[6:0], cap_o[i][0]};
        if (cap_oe[i] != 4'b0001) oe_ok = 0;
      end
      chk(gb == opc, "R2 opcode", gb, opc);
      chk(oe_ok, "R2 opcode line enable", 0, 1);
    end
    ga = '0; oe_ok = 1;
    for (int c = 0; c < ac; c++) begin
      ga = (al == 4) ? {ga[27:0], cap_o[off + c]} : {ga[30:0], cap_o[off + c][0]};
      if (cap_oe[off + c] != ((al == 4) ? 4'b1111 : 4'b0001)) oe_ok = 0;
    end
    chk(ga == cur_addr, cont ? "R8 address first" : "R3 address", ga, cur_addr);
    chk(oe_ok, "R3 address line enable", 0, 1);
    if (mcyc * al == 8) begin
      gb = '0;
      for (int c = 0; c < mcyc; c++)
        gb = (al == 4) ? {gb[3:0], cap_o[off + ac + c]} : {gb[6:0], cap_o[off + ac + c][0]};
      chk(gb == mb, "R4 mode byte", gb, mb);
    end
    oe_ok = 1;
    for (int k = off + ac + mcyc; k < nrise && k < 4096; k++)
      if (cap_oe[k] != 4'b0000) oe_ok = 0;
    chk(oe_ok, "R5 lines released dummy/data", 0, 1);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int sel_before;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && rd_valid == 0 && io_oe == 0,
        "R1 reset state", {cs_n, sclk, busy, rd_valid}, 4'b1000);
    // R2 R3 R6: 1-1-1, 3-byte address
    run(8'h0B, 32'h00123456, 0, 2'd0, 0, 8, 8'h00, 4, 0, 0);
    // R7: 1-1-4, 512 bytes, issued back to back
    run(8'h6B, 32'h00000100, 0, 2'd1, 0, 8, 8'h00, 512, 0, 0);
    // R7 R4: 1-4-4, mode 0xFF, 512 bytes
    run(8'hEB, 32'h00ABC000, 0, 2'd2, 2, 4, 8'hFF, 512, 0, 0);
    // R3 R4 R9: 1-4-4, 4-byte address, request poked while busy
    sel_before = n_sel;
    run(8'hEC, 32'h89ABCDEF, 1, 2'd2, 2, 8, 8'hA5, 5, 0, 1);
    repeat (30) @(negedge clk);
    chk(n_sel == sel_before + 1 && cs_n == 1, "R9 request while busy ignored",
        n_sel - sel_before, 1);
    // R8: continuous request
    run(8'hEB, 32'h00004321, 0, 2'd2, 2, 4, 8'h20, 3, 1, 0);
    // R5: single line, 4-byte address, no dummy
    run(8'h13, 32'h01020304, 1, 2'd0, 0, 0, 8'h00, 2, 0, 0);
    chk(min_gap >= 2, "R9 deselect gap", min_gap, 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule